// File: doc/BRIEF.md
# Four-Link Message Serializer

This block is a host-bus peripheral that gives an 8-bit processor four independent point-to-point message links. Each link owns a 256-byte slice of host address space. The host copies a whole message into that slice with block moves, then writes a single start command. The hardware frames the message, shifts it out on the link's serial line, and raises an interrupt when the far end has answered. The host does not poll each byte.

The far end is another copy of the same block. Its receiver rebuilds the message into its own window, sets a receive-ready flag and interrupts its host, which can then block-read the payload. While that flag is set the receive window is locked. A further frame arriving in that state is thrown away, and the sender is told so by a negative response symbol. The serial bit time comes from a per-link divisor of the system clock.

Each link has a data line out, a data line in, a response line out and a response line in. Host reads return data one cycle after the strobe.

Top module: `msglink_top`

## Requirements
- R1: With bus_addr[10]=0, bus_addr[9:8] picks the link and bus_addr[7:0] the byte. A write lands in that link's transmit buffer and a read returns that link's receive buffer. A message sent from link L appears at the same offsets in the window of its peer.
- R2: Writing a value with bit 0 set to the command register (bus_addr = 0x400 + 8*L + 1) starts a send of the loaded message. When the peer's response arrives, status bit 0 (busy) clears and status bit 1 (done) sets.
- R3: When a well-formed frame is taken into an unlocked window, status bit 2 (receive-ready) sets. The length register (offset 0) then reads the received length field, and the window holds the payload bytes.
- R4: A length of 0, written to the length register (offset 0), sends and receives a 256-byte message.
- R5: Line format: the line idles high. Each byte is a 0 start bit, eight data bits LSB first, then a 1 stop bit. A frame is 0xA5, the length byte, the payload and 0x5A. The receiver answers on its response line with 0x06 (accepted) or 0x15 (rejected).
- R6: The divisor register (offset 4) resets to 8. One bit lasts max(divisor, 4) clock cycles.
- R7: The status register is at offset 2. Writing 1 to bit 1, 2, 3 or 4 clears that bit, and a bit that has been cleared reads 0.
- R8: irq is the registered OR, over all links, of (done AND enable bit 0) and (receive-ready AND enable bit 1). The enable register is at offset 3. With both enables 0, irq stays 0.
- R9: A start written while busy is ignored and sets sticky status bit 3 (overrun). Exactly one message is delivered.
- R10: While receive-ready is set, an incoming frame is not written and the received length is kept. The sender ends with done and status bit 4 (rejected) set.
- R11: After reset every status register reads 0, the divisor reads 8, irq is 0 and every data and response line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Window or register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Interrupt request |
| ser_out | output | 4 | Per-link outgoing data line |
| ser_in | input | 4 | Per-link incoming data line |
| rsp_out | output | 4 | Per-link response line to the sender |
| rsp_in | input | 4 | Per-link response line from the peer |

## Verification
The links are cross-wired in pairs: 0 with 1, and 2 with 3. Messages go in both directions on both pairs. Lengths run from 1 and 3 up to 200, plus the 0-means-256 case, and each message uses its own byte pattern. This separates per-link decode errors, offset slips and count errors at the message end. The line is sampled bit by bit to confirm the start marker, the length byte and the bit time, including a divisor below the floor. Directed cases cover a double start, a frame sent into a locked window, and masked interrupts. These tell ignored commands and rejected frames apart from silent corruption.

// File: rtl/msglink_pkg.sv
package msglink_pkg;
  localparam logic [7:0] SOF_SYM = 8'hA5;
  localparam logic [7:0] EOF_SYM = 8'h5A;
  localparam logic [7:0] ACK_SYM = 8'h06;
  localparam logic [7:0] NAK_SYM = 8'h15;

  localparam logic [2:0] R_LEN  = 3'd0;
  localparam logic [2:0] R_CMD  = 3'd1;
  localparam logic [2:0] R_STAT = 3'd2;
  localparam logic [2:0] R_IEN  = 3'd3;
  localparam logic [2:0] R_DIV  = 3'd4;

  typedef enum logic [2:0] {T_IDLE, T_SOF, T_LEN, T_PAY, T_EOF, T_WAIT} tx_state_t;
  typedef enum logic [1:0] {X_SOF, X_LEN, X_PAY, X_EOF} rx_state_t;
endpackage

// File: rtl/msglink_ser.sv
module msglink_ser (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] div,
  input  logic       go,
  input  logic [7:0] din,
  output logic       line,
  output logic       busy
);
  logic [8:0] sh;
  logic [3:0] nbit;
  logic [7:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= 1'b1; busy <= 1'b0; sh <= '1; nbit <= '0; tmr <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1; line <= 1'b0; sh <= {1'b1, din}; nbit <= '0; tmr <= div - 8'd1;
      end
    end else if (tmr != 8'd0) begin
      tmr <= tmr - 8'd1;
    end else if (nbit == 4'd9) begin
      busy <= 1'b0; line <= 1'b1;
    end else begin
      line <= sh[0]; sh <= {1'b1, sh[8:1]}; nbit <= nbit + 4'd1; tmr <= div - 8'd1;
    end
  end

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst) !busy |-> line);
endmodule

// File: rtl/msglink_des.sv
module msglink_des (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] div,
  input  logic       line,
  output logic       vld,
  output logic [7:0] dout
);
  logic       s1, s2, active;
  logic [3:0] nbit;
  logic [7:0] tmr, sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; active <= 1'b0; nbit <= '0; tmr <= '0;
      sh <= '0; vld <= 1'b0; dout <= '0;
    end else begin
      s1 <= line; s2 <= s1; vld <= 1'b0;
      if (!active) begin
        if (!s2) begin active <= 1'b1; tmr <= div >> 1; nbit <= '0; end
      end else if (tmr != 8'd0) begin
        tmr <= tmr - 8'd1;
      end else if (nbit == 4'd0) begin
        if (s2) active <= 1'b0;
        else begin nbit <= 4'd1; tmr <= div - 8'd1; end
      end else if (nbit <= 4'd8) begin
        sh <= {s2, sh[7:1]}; nbit <= nbit + 4'd1; tmr <= div - 8'd1;
      end else begin
        active <= 1'b0;
        if (s2) begin vld <= 1'b1; dout <= sh; end
      end
    end
  end
endmodule

// File: rtl/msglink_link.sv
module msglink_link
  import msglink_pkg::*;
#(
  parameter int         WIN_AW  = 8,
  parameter logic [7:0] DIV_RST = 8'd8,
  parameter logic [7:0] DIV_MIN = 8'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_wr,
  input  logic              win_rd,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [WIN_AW-1:0] off,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              pend,
  output logic              ser_out,
  input  logic              ser_in,
  output logic              rsp_out,
  input  logic              rsp_in
);
  localparam int DEPTH = 1 << WIN_AW;
  localparam int CNT_W = WIN_AW + 1;

  logic [7:0] txmem [DEPTH];
  logic [7:0] rxmem [DEPTH];
  logic [7:0] tx_q, win_q, reg_q, div, eff_div, dtx_byte, drx_byte, rv_byte, rsp_byte;
  logic [WIN_AW-1:0] txlen, rxlen, cur_len, tx_ptr, rx_ptr;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [1:0] ien;
  logic busy, done, ovr, nak, rxrdy, rej;
  logic dtx_go, dtx_busy, drx_vld, rv_vld, rsp_go, rsp_busy, rx_we, rd_win, rd_reg;
  tx_state_t ts;
  rx_state_t rs;

  wire [2:0] roff      = off[2:0];
  wire       start_req = reg_wr && roff == R_CMD && wdata[0];
  wire       stat_wr   = reg_wr && roff == R_STAT;

  assign eff_div = (div < DIV_MIN) ? DIV_MIN : div;
  assign pend    = (done && ien[0]) || (rxrdy && ien[1]);

  // buffers, one write and one registered read port each
  always_ff @(posedge clk) begin
    if (win_wr) txmem[off] <= wdata;
    tx_q <= txmem[tx_ptr];
  end
  always_ff @(posedge clk) begin
    if (rx_we) rxmem[rx_ptr] <= drx_byte;
    win_q <= rxmem[off];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div <= DIV_RST; ien <= '0; txlen <= '0;
    end else if (reg_wr) begin
      case (roff)
        R_LEN:   txlen <= wdata[WIN_AW-1:0];
        R_IEN:   ien   <= wdata[1:0];
        R_DIV:   div   <= wdata;
        default: ;
      endcase
    end
  end

  // transmit framing
  always_comb begin
    dtx_go = 1'b0; dtx_byte = SOF_SYM;
    case (ts)
      T_SOF:   begin dtx_go = !dtx_busy; dtx_byte = SOF_SYM; end
      T_LEN:   begin dtx_go = !dtx_busy; dtx_byte = 8'(txlen); end
      T_PAY:   begin dtx_go = !dtx_busy; dtx_byte = tx_q; end
      T_EOF:   begin dtx_go = !dtx_busy; dtx_byte = EOF_SYM; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts <= T_IDLE; busy <= 1'b0; done <= 1'b0; ovr <= 1'b0; nak <= 1'b0;
      tx_ptr <= '0; tx_cnt <= '0;
    end else begin
      if (stat_wr) begin
        if (wdata[1]) done <= 1'b0;
        if (wdata[3]) ovr  <= 1'b0;
        if (wdata[4]) nak  <= 1'b0;
      end
      if (start_req) begin
        if (busy) ovr <= 1'b1;
        else begin
          busy <= 1'b1; done <= 1'b0; nak <= 1'b0; ts <= T_SOF; tx_ptr <= '0;
          tx_cnt <= (txlen == '0) ? CNT_W'(DEPTH) : CNT_W'(txlen);
        end
      end
      case (ts)
        T_SOF: if (!dtx_busy) ts <= T_LEN;
        T_LEN: if (!dtx_busy) ts <= T_PAY;
        T_PAY: if (!dtx_busy) begin
          tx_ptr <= tx_ptr + 1'b1; tx_cnt <= tx_cnt - 1'b1;
          if (tx_cnt == CNT_W'(1)) ts <= T_EOF;
        end
        T_EOF: if (!dtx_busy) ts <= T_WAIT;
        T_WAIT: if (rv_vld && (rv_byte == ACK_SYM || rv_byte == NAK_SYM)) begin
          ts <= T_IDLE; busy <= 1'b0; done <= 1'b1;
          if (rv_byte == NAK_SYM) nak <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // receive framing
  assign rx_we = (rs == X_PAY) && drx_vld && !rej;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs <= X_SOF; rxrdy <= 1'b0; rxlen <= '0; cur_len <= '0; rej <= 1'b0;
      rx_ptr <= '0; rx_cnt <= '0; rsp_go <= 1'b0; rsp_byte <= ACK_SYM;
    end else begin
      rsp_go <= 1'b0;
      if (stat_wr && wdata[2]) rxrdy <= 1'b0;
      if (drx_vld) begin
        case (rs)
          X_SOF: if (drx_byte == SOF_SYM) rs <= X_LEN;
          X_LEN: begin
            cur_len <= drx_byte[WIN_AW-1:0];
            rx_cnt  <= (drx_byte == 8'd0) ? CNT_W'(DEPTH) : CNT_W'(drx_byte);
            rej <= rxrdy; rx_ptr <= '0; rs <= X_PAY;
          end
          X_PAY: begin
            rx_ptr <= rx_ptr + 1'b1; rx_cnt <= rx_cnt - 1'b1;
            if (rx_cnt == CNT_W'(1)) rs <= X_EOF;
          end
          X_EOF: begin
            rs <= X_SOF; rsp_go <= 1'b1;
            if (drx_byte == EOF_SYM && !rej) begin
              rxrdy <= 1'b1; rxlen <= cur_len; rsp_byte <= ACK_SYM;
            end else rsp_byte <= NAK_SYM;
          end
          default: rs <= X_SOF;
        endcase
      end
    end
  end

  // host read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_win <= 1'b0; rd_reg <= 1'b0; reg_q <= '0;
    end else begin
      rd_win <= win_rd; rd_reg <= reg_rd;
      if (reg_rd) begin
        case (roff)
          R_LEN:   reg_q <= 8'(rxlen);
          R_STAT:  reg_q <= {3'b000, nak, ovr, rxrdy, done, busy};
          R_IEN:   reg_q <= {6'b0, ien};
          R_DIV:   reg_q <= div;
          default: reg_q <= '0;
        endcase
      end
    end
  end
  assign rdata = rd_win ? win_q : (rd_reg ? reg_q : 8'h00);

  msglink_ser u_dtx (.clk, .rst, .div(eff_div), .go(dtx_go), .din(dtx_byte),
                     .line(ser_out), .busy(dtx_busy));
  msglink_des u_drx (.clk, .rst, .div(eff_div), .line(ser_in), .vld(drx_vld), .dout(drx_byte));
  msglink_ser u_rtx (.clk, .rst, .div(eff_div), .go(rsp_go && !rsp_busy), .din(rsp_byte),
                     .line(rsp_out), .busy(rsp_busy));
  msglink_des u_rrx (.clk, .rst, .div(eff_div), .line(rsp_in), .vld(rv_vld), .dout(rv_byte));

  assert_done_with_finish_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (start_req && busy) |=> ovr);
  assert_rx_locked_R10: assert property (@(posedge clk) disable iff (rst)
    rxrdy |-> !rx_we);
  assert_rxlen_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rxrdy && $past(rxrdy)) |-> $stable(rxlen));
endmodule

// File: rtl/msglink_top.sv
module msglink_top
  import msglink_pkg::*;
#(
  parameter int         LINKS   = 4,
  parameter int         WIN_AW  = 8,
  parameter logic [7:0] DIV_RST = 8'd8,
  parameter logic [7:0] DIV_MIN = 8'd4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_sel,
  input  logic                             bus_wr,
  input  logic [WIN_AW+$clog2(LINKS):0]    bus_addr,
  input  logic [7:0]                       bus_wdata,
  output logic [7:0]                       bus_rdata,
  output logic                             irq,
  output logic [LINKS-1:0]                 ser_out,
  input  logic [LINKS-1:0]                 ser_in,
  output logic [LINKS-1:0]                 rsp_out,
  input  logic [LINKS-1:0]                 rsp_in
);
  localparam int LINK_W = $clog2(LINKS);

  wire              is_reg   = bus_addr[WIN_AW+LINK_W];
  wire [LINK_W-1:0] win_link = bus_addr[WIN_AW +: LINK_W];
  wire [LINK_W-1:0] reg_link = bus_addr[3 +: LINK_W];
  wire [WIN_AW-1:0] off      = is_reg ? WIN_AW'(bus_addr[2:0]) : bus_addr[WIN_AW-1:0];

  logic [7:0]       rd_all [LINKS];
  logic [LINKS-1:0] pend;

  for (genvar i = 0; i < LINKS; i++) begin : g_link
    wire win_hit = bus_sel && !is_reg && win_link == LINK_W'(i);
    wire reg_hit = bus_sel &&  is_reg && reg_link == LINK_W'(i);
    msglink_link #(.WIN_AW(WIN_AW), .DIV_RST(DIV_RST), .DIV_MIN(DIV_MIN)) u_link (
      .clk, .rst,
      .win_wr(win_hit && bus_wr), .win_rd(win_hit && !bus_wr),
      .reg_wr(reg_hit && bus_wr), .reg_rd(reg_hit && !bus_wr),
      .off, .wdata(bus_wdata), .rdata(rd_all[i]), .pend(pend[i]),
      .ser_out(ser_out[i]), .ser_in(ser_in[i]), .rsp_out(rsp_out[i]), .rsp_in(rsp_in[i]));
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < LINKS; k++) bus_rdata |= rd_all[k];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend;
  end
endmodule

// File: tb/msglink_top_tb.sv
module msglink_top_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, bus_sel, bus_wr, irq;
  logic [10:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] ser_out, ser_in, rsp_out, rsp_in;

  assign ser_in = {ser_out[2], ser_out[3], ser_out[0], ser_out[1]};
  assign rsp_in = {rsp_out[2], rsp_out[3], rsp_out[0], rsp_out[1]};

  msglink_top u_dut (.clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
                     .irq, .ser_out, .ser_in, .rsp_out, .rsp_in);

  int n_chk = 0, n_bad = 0;
  logic smp [256];

  // {tx link, length, seed}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 8'd1,   8'h11}, {2'd0, 8'd4, 8'h3C}, {2'd1, 8'd16, 8'h80},
    {2'd2, 8'd3,   8'hF0}, {2'd3, 8'd200, 8'h07}, {2'd0, 8'd0, 8'h5A}};

  function automatic logic [10:0] raddr(int lk, int r);
    return 11'h400 | 11'(lk * 8 + r);
  endfunction
  function automatic logic [7:0] pat(int seed, int k);
    return 8'(seed + k * 29 + (k >> 3));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask
  task automatic rd(logic [10:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
  endtask

  task automatic load_msg(int lk, int len, int seed);
    int n = (len == 0) ? 256 : len;
    for (int k = 0; k < n; k++) wr(11'(lk * 256 + k), pat(seed, k));
    wr(raddr(lk, 0), 8'(len));
  endtask
  task automatic kick(int lk);
    wr(raddr(lk, 1), 8'h01);
  endtask
  task automatic wait_idle(int lk);
    logic [7:0] s;
    for (int i = 0; i < 40000; i++) begin
      rd(raddr(lk, 2), s);
      if (!s[0]) break;
    end
  endtask
  task automatic check_win(string tag, int lk, int len, int seed);
    logic [7:0] d;
    int n = (len == 0) ? 256 : len;
    int bad_at = -1;
    logic [7:0] got = 0, exp = 0;
    for (int k = 0; k < n; k++) begin
      rd(11'(lk * 256 + k), d);
      if (d != pat(seed, k) && bad_at < 0) begin bad_at = k; got = d; exp = pat(seed, k); end
    end
    chk(tag, got, exp);
  endtask
  task automatic rdchk(string tag, logic [10:0] a, int exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask
  task automatic capture(int lk, int div);
    int t = 0;
    while (ser_out[lk] && t < 2000) begin @(negedge clk); t++; end
    for (int i = 0; i < 25 * div; i++) begin smp[i] = ser_out[lk]; @(negedge clk); end
  endtask
  function automatic int low_run();
    int c = 0;
    while (c < 255 && !smp[c]) c++;
    return c;
  endfunction
  function automatic logic [7:0] byte_at(int st, int div);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = smp[st + div * (i + 1) + div / 2];
    return b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int st2;
    rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state, R6 default divisor
    chk("R11 irq", irq, 0);
    chk("R11 lines", {ser_out, rsp_out}, 8'hFF);
    for (int lk = 0; lk < 4; lk++) begin
      rdchk("R11 status", raddr(lk, 2), 0);
      rdchk("R6 divisor reset", raddr(lk, 4), 8);
    end
    for (int lk = 0; lk < 4; lk++) begin wr(raddr(lk, 4), 8'd5); wr(raddr(lk, 3), 8'h03); end

    // vector table: R1 R2 R3 R4 R7 R8
    for (int v = 0; v < 6; v++) begin
      int lk = VEC[v][17:16], len = VEC[v][15:8], seed = VEC[v][7:0];
      int pr = lk ^ 1;
      load_msg(lk, len, seed);
      kick(lk);
      wait_idle(lk);
      rdchk("R2 sender done", raddr(lk, 2), 8'h02);
      rdchk("R3 peer ready", raddr(pr, 2), 8'h04);
      rdchk("R3 R4 peer length", raddr(pr, 0), len);
      check_win("R1 R4 peer window", pr, len, seed);
      chk("R8 irq set", irq, 1);
      wr(raddr(lk, 2), 8'h02);
      wr(raddr(pr, 2), 8'h04);
      rdchk("R7 sender cleared", raddr(lk, 2), 0);
      rdchk("R7 peer cleared", raddr(pr, 2), 0);
      chk("R8 irq clear", irq, 0);
    end

    // R9 start while busy
    load_msg(0, 8, 8'h21);
    kick(0);
    kick(0);
    rdchk("R9 overrun while busy", raddr(0, 2), 8'h09);
    wait_idle(0);
    rdchk("R9 overrun sticky", raddr(0, 2), 8'h0A);
    rdchk("R9 single delivery len", raddr(1, 0), 8);
    check_win("R9 single delivery data", 1, 8, 8'h21);
    wr(raddr(0, 2), 8'h0A);
    rdchk("R7 overrun cleared", raddr(0, 2), 0);

    // R10 locked window (link1 still holds receive-ready)
    load_msg(0, 5, 8'h99);
    kick(0);
    wait_idle(0);
    rdchk("R10 sender rejected", raddr(0, 2), 8'h12);
    rdchk("R10 peer still ready", raddr(1, 2), 8'h04);
    rdchk("R10 length kept", raddr(1, 0), 8);
    check_win("R10 window kept", 1, 8, 8'h21);
    wr(raddr(0, 2), 8'h12);
    wr(raddr(1, 2), 8'h04);
    rdchk("R7 reject cleared", raddr(0, 2), 0);

    // R8 masked interrupts
    wr(raddr(0, 3), 8'h00);
    wr(raddr(1, 3), 8'h00);
    load_msg(0, 2, 8'h44);
    kick(0);
    wait_idle(0);
    rdchk("R8 masked done present", raddr(0, 2), 8'h02);
    chk("R8 irq masked", irq, 0);
    wr(raddr(1, 3), 8'h02);
    @(negedge clk);
    chk("R8 irq on rx enable", irq, 1);
    wr(raddr(0, 2), 8'h02);
    wr(raddr(1, 2), 8'h04);
    @(negedge clk);
    chk("R8 irq after clear", irq, 0);

    // R5 R6 line format with divisor 6
    wr(raddr(2, 4), 8'd6);
    wr(raddr(3, 4), 8'd6);
    rdchk("R6 divisor readback", raddr(2, 4), 6);
    load_msg(2, 2, 8'h40);
    kick(2);
    capture(2, 6);
    chk("R6 bit time 6", low_run(), 6);
    chk("R5 start marker", byte_at(0, 6), 8'hA5);
    st2 = 60;
    while (st2 < 140 && smp[st2]) st2++;
    chk("R5 length byte", byte_at(st2, 6), 8'h02);
    wait_idle(2);
    check_win("R5 framed payload", 3, 2, 8'h40);
    wr(raddr(2, 2), 8'h02);
    wr(raddr(3, 2), 8'h04);

    // R6 divisor below floor
    wr(raddr(0, 4), 8'd1);
    wr(raddr(1, 4), 8'd1);
    rdchk("R6 low divisor readback", raddr(0, 4), 1);
    load_msg(0, 1, 8'hC3);
    kick(0);
    capture(0, 4);
    chk("R6 bit time floor", low_run(), 4);
    wait_idle(0);
    check_win("R6 floor payload", 1, 1, 8'hC3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule